// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block gathers eight interrupt conditions into a status register, qualifies them with a software mask, and raises one active-low request whenever any enabled condition is present. A host reaches three registers through a small register interface: status (read-only), mask and vector. A chip select qualifies each access, and a read/write strobe and a two-bit address go with it. Every register access is handshaken by an active-low transfer-acknowledge output.

When the host processor answers the request, it runs an interrupt-acknowledge cycle. If an unmasked condition is pending at the start of that cycle, the block returns its programmable 8-bit vector on the read data path and acknowledges the transfer. If nothing is pending, it neither drives the read data nor acknowledges, and the host's own bus timer ends the cycle. A bus state machine sequences both kinds of cycle.

The bus state machine has four states:

- `ST_IDLE` waits for a cycle to begin.
  - It moves to `ST_REG_ACK` when select falls.
  - It moves to `ST_VEC_ACK` when acknowledge falls while an interrupt is pending.
  - It moves to `ST_NO_ACK` when acknowledge falls with nothing pending.
- `ST_REG_ACK` handshakes a register access and returns to `ST_IDLE` once select is released.
- `ST_VEC_ACK` presents the vector and returns to `ST_IDLE` once acknowledge is released.
- `ST_NO_ACK` stays silent and returns to `ST_IDLE` once acknowledge is released.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the status and mask registers read 0x00 and the vector register reads 0x0F. The request is high, transfer-acknowledge is high and the read-drive flag is low.
- R2: The status register captures the eight source levels on every clock, with bit i holding source i. A read at address 0 returns the levels that were held for at least one clock before the access started.
- R3: The request output is low exactly when the bitwise AND of status and mask is nonzero. It therefore follows a source change one clock later, and it follows a mask write from the clock edge that starts the write.
- R4: A write at address 1 loads the mask and a write at address 2 loads the vector, and both read back at the same addresses. Writes at address 0 (status) and address 3 change no register, and a read at address 3 returns 0x00.
- R5: A register access (select low while acknowledge is high) drives transfer-acknowledge low from the first clock edge with select low until the first edge with select high. The read-drive flag is high in that window only for reads (read/write input = 1), and it is never high while transfer-acknowledge is high.
- R6: An interrupt-acknowledge cycle that starts while an unmasked condition is pending holds transfer-acknowledge low and drives the vector register value on the read data, with the read-drive flag high, until acknowledge is released.
- R7: An interrupt-acknowledge cycle that starts with nothing pending keeps transfer-acknowledge high and the read-drive flag low for its whole length, even if a condition becomes pending during it.
- R8: When select and acknowledge fall together in idle, the acknowledge cycle wins, and any write requested in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cond | input | 8 | Interrupt source levels, one per bit |
| sel_n | input | 1 | Active-low register select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 vector |
| wdata | input | 8 | Write data |
| iack_n | input | 1 | Active-low interrupt-acknowledge cycle input |
| rdata | output | 8 | Read data; 0 when not driven |
| rdata_oe | output | 1 | High while the block drives the read data bus |
| xfer_ack_n | output | 1 | Active-low transfer acknowledge |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the host holds address, read/write and write data stable while select is low. They also assume that select and acknowledge, once lowered, stay low until the block acknowledges, or, for an unanswered acknowledge, until the host gives up. The bench drives every bus input on the falling clock edge. It holds each cycle's controls steady until it releases select or acknowledge, and it changes the sources only between bus cycles, except in the directed case that raises a source during an unanswered acknowledge. Random source patterns, masks, vectors and addresses are drawn within these rules from a fixed seed.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REG_ACK = 2'd1,
        ST_VEC_ACK = 2'd2,
        ST_NO_ACK  = 2'd3
    } bus_state_t;

    localparam int unsigned ADDR_STATUS = 0;
    localparam int unsigned ADDR_MASK   = 1;
    localparam int unsigned ADDR_VECTOR = 2;

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
    parameter int unsigned       N_SRC     = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_cond,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_SRC-1:0]  status_q,
    output logic [N_SRC-1:0]  mask_q,
    output logic [DATA_W-1:0] vec_q,
    output logic              any_pending
);
    import irq_vec_pkg::*;

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(ADDR_VECTOR);

    logic [N_SRC-1:0] masked;

    // Status tracks source levels; no latching of edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= src_cond;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && (addr == A_MASK)) begin
            mask_q <= wdata[N_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= VEC_RESET;
        end else if (wr_en && (addr == A_VEC)) begin
            vec_q <= wdata;
        end
    end

    always_comb begin
        masked      = status_q & mask_q;
        any_pending = |masked;
    end

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_vec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_n,
    input  logic       iack_n,
    input  logic       rd_wr,
    input  logic       any_pending,
    output bus_state_t state,
    output logic       reg_start,
    output logic       vec_start,
    output logic       xfer_ack_n,
    output logic       read_oe
);
    bus_state_t state_nx;
    logic       is_read_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Direction of the current register access, held for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
        end else if (reg_start) begin
            is_read_q <= rd_wr;
        end
    end

    // Next state; acknowledge has priority over select in idle
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!iack_n) begin
                    state_nx = any_pending ? ST_VEC_ACK : ST_NO_ACK;
                end else if (!sel_n) begin
                    state_nx = ST_REG_ACK;
                end
            end
            ST_REG_ACK: begin
                if (sel_n) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_VEC_ACK: begin
                if (iack_n) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_NO_ACK: begin
                if (iack_n) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // Outputs and start strobes
    always_comb begin
        reg_start  = 1'b0;
        vec_start  = 1'b0;
        xfer_ack_n = 1'b1;
        read_oe    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                vec_start = !iack_n && any_pending;
                reg_start = iack_n && !sel_n;
            end
            ST_REG_ACK: begin
                xfer_ack_n = 1'b0;
                read_oe    = is_read_q;
            end
            ST_VEC_ACK: begin
                xfer_ack_n = 1'b0;
                read_oe    = 1'b1;
            end
            ST_NO_ACK: begin
                xfer_ack_n = 1'b1;
                read_oe    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_read_path.sv
module irq_read_path #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_start,
    input  logic              vec_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  status_q,
    input  logic [N_SRC-1:0]  mask_q,
    input  logic [DATA_W-1:0] vec_q,
    output logic [DATA_W-1:0] rdata_q
);
    import irq_vec_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(ADDR_VECTOR);

    logic [DATA_W-1:0] reg_sel;

    always_comb begin
        reg_sel = '0;
        if (addr == A_STAT) begin
            reg_sel = DATA_W'(status_q);
        end else if (addr == A_MASK) begin
            reg_sel = DATA_W'(mask_q);
        end else if (addr == A_VEC) begin
            reg_sel = vec_q;
        end
    end

    // Read data is captured once, at the start of the cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (vec_start) begin
            rdata_q <= vec_q;
        end else if (reg_start) begin
            rdata_q <= reg_sel;
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned       N_SRC     = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_cond,
    input  logic              sel_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              iack_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              xfer_ack_n,
    output logic              irq_n
);
    logic [N_SRC-1:0]  status_q;
    logic [N_SRC-1:0]  mask_q;
    logic [DATA_W-1:0] vec_q;
    logic [DATA_W-1:0] rdata_q;
    logic              any_pending;
    logic              reg_start;
    logic              vec_start;
    logic              read_oe;
    logic              wr_en;
    bus_state_t        state;

    assign wr_en = reg_start && !rd_wr;

    irq_src_regs #(
        .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RESET)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .status_q(status_q), .mask_q(mask_q),
        .vec_q(vec_q), .any_pending(any_pending)
    );

    irq_bus_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .iack_n(iack_n),
        .rd_wr(rd_wr), .any_pending(any_pending), .state(state),
        .reg_start(reg_start), .vec_start(vec_start),
        .xfer_ack_n(xfer_ack_n), .read_oe(read_oe)
    );

    irq_read_path #(
        .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .reg_start(reg_start), .vec_start(vec_start),
        .addr(addr), .status_q(status_q), .mask_q(mask_q), .vec_q(vec_q),
        .rdata_q(rdata_q)
    );

    assign rdata    = read_oe ? rdata_q : '0;
    assign rdata_oe = read_oe;
    assign irq_n    = !any_pending;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vec_pkg::*;
#(
    parameter int unsigned       N_SRC     = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       ADDR_W    = 2,
    parameter logic [DATA_W-1:0] VEC_RESET = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_cond,
    input logic              sel_n,
    input logic              rd_wr,
    input logic [ADDR_W-1:0] addr,
    input logic              iack_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              xfer_ack_n,
    input logic              irq_n,
    input logic [N_SRC-1:0]  mask_q,
    input logic [DATA_W-1:0] vec_q,
    input bus_state_t        state
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (vec_q == VEC_RESET && mask_q == '0 && irq_n && xfer_ack_n && !rdata_oe));

    assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_n == !(|($past(src_cond) & mask_q))));

    assert_status_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sel_n && iack_n && !rd_wr && addr == ADDR_W'(ADDR_STATUS))
        |=> ($stable(mask_q) && $stable(vec_q)));

    assert_ack_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !xfer_ack_n) |-> ($past(!sel_n) || $past(!iack_n)));

    assert_oe_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !xfer_ack_n);

    assert_vec_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_ACK) |-> (rdata_oe && !xfer_ack_n && rdata == vec_q));

    assert_noack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NO_ACK) |-> (xfer_ack_n && !rdata_oe));

    assert_iack_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state == ST_IDLE && !iack_n && !sel_n)) |-> (state != ST_REG_ACK));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RESET)
) chk_i (
    .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .sel_n(sel_n),
    .rd_wr(rd_wr), .addr(addr), .iack_n(iack_n), .rdata(rdata),
    .rdata_oe(rdata_oe), .xfer_ack_n(xfer_ack_n), .irq_n(irq_n),
    .mask_q(mask_q), .vec_q(vec_q), .state(state)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] src_cond;
    logic       sel_n;
    logic       rd_wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic       iack_n;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       xfer_ack_n;
    logic       irq_n;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [7:0]  m_mask;
    logic [7:0]  m_vec;

    always #10 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .sel_n(sel_n),
        .rd_wr(rd_wr), .addr(addr), .wdata(wdata), .iack_n(iack_n),
        .rdata(rdata), .rdata_oe(rdata_oe), .xfer_ack_n(xfer_ack_n), .irq_n(irq_n)
    );

    function automatic logic exp_irq_n(input logic [7:0] s, input logic [7:0] m);
        return !(|(s & m));
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [7:0] s,
                                            input logic [7:0] m, input logic [7:0] v);
        case (a)
            2'd0:    return s;
            2'd1:    return m;
            2'd2:    return v;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_n = 1'b0; rd_wr = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        check("R5", "write ack low", {31'd0, xfer_ack_n}, 32'd0);
        check("R5", "write no drive", {31'd0, rdata_oe}, 32'd0);
        sel_n = 1'b1;
        @(negedge clk);
        check("R5", "write ack released", {31'd0, xfer_ack_n}, 32'd1);
        if (a == 2'd1) m_mask = d;
        if (a == 2'd2) m_vec = d;
    endtask

    task automatic bus_read(input logic [1:0] a, input string req, input logic [7:0] expv);
        @(negedge clk);
        sel_n = 1'b0; rd_wr = 1'b1; addr = a;
        @(negedge clk);
        check("R5", "read ack low", {31'd0, xfer_ack_n}, 32'd0);
        check("R5", "read drive", {31'd0, rdata_oe}, 32'd1);
        check(req, "read data", {24'd0, rdata}, {24'd0, expv});
        sel_n = 1'b1;
        @(negedge clk);
        check("R5", "read released", {30'd0, xfer_ack_n, rdata_oe}, 32'd2);
    endtask

    task automatic iack_cycle(input logic pend);
        @(negedge clk);
        iack_n = 1'b0;
        @(negedge clk);
        if (pend) begin
            check("R6", "vector ack", {31'd0, xfer_ack_n}, 32'd0);
            check("R6", "vector drive", {31'd0, rdata_oe}, 32'd1);
            check("R6", "vector value", {24'd0, rdata}, {24'd0, m_vec});
        end else begin
            check("R7", "no ack", {30'd0, xfer_ack_n, rdata_oe}, 32'd2);
        end
        iack_n = 1'b1;
        @(negedge clk);
        check("R6", "iack released", {30'd0, xfer_ack_n, rdata_oe}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        rst_n = 1'b0; src_cond = 8'hA5; sel_n = 1'b1; rd_wr = 1'b1;
        addr = 2'd0; wdata = 8'h00; iack_n = 1'b1;
        m_mask = 8'h00; m_vec = 8'h0F;
        repeat (3) @(negedge clk);
        check("R1", "reset irq", {31'd0, irq_n}, 32'd1);
        check("R1", "reset ack/oe", {30'd0, xfer_ack_n, rdata_oe}, 32'd2);
        rst_n = 1'b1;
        src_cond = 8'h00;
        @(negedge clk);
        bus_read(2'd1, "R1", 8'h00);
        bus_read(2'd2, "R1", 8'h0F);
        bus_read(2'd0, "R1", 8'h00);

        // R2 / R3 directed
        src_cond = 8'h81;
        @(negedge clk);
        check("R3", "masked source no irq", {31'd0, irq_n}, 32'd1);
        bus_read(2'd0, "R2", 8'h81);
        bus_write(2'd1, 8'h80);
        check("R3", "mask enables irq", {31'd0, irq_n}, 32'd0);
        src_cond = 8'h01;
        @(negedge clk);
        check("R3", "irq drops with source", {31'd0, irq_n}, 32'd1);

        // R4: status and address 3 writes ignored
        bus_write(2'd0, 8'hFF);
        bus_write(2'd3, 8'h3C);
        bus_read(2'd1, "R4", 8'h80);
        bus_read(2'd2, "R4", 8'h0F);
        bus_read(2'd3, "R4", 8'h00);
        bus_read(2'd0, "R4", 8'h01);

        // R6: vector ack with pending
        bus_write(2'd2, 8'h5A);
        bus_write(2'd1, 8'h01);
        iack_cycle(1'b1);

        // R7: none pending, source rises during the cycle
        bus_write(2'd1, 8'hFF);
        src_cond = 8'h00;
        @(negedge clk);
        iack_n = 1'b0;
        @(negedge clk);
        src_cond = 8'h10;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7", "quiet during late pending", {30'd0, xfer_ack_n, rdata_oe}, 32'd2);
        end
        iack_n = 1'b1;
        @(negedge clk);
        check("R3", "irq from late source", {31'd0, irq_n}, 32'd0);

        // R8: select and acknowledge together
        @(negedge clk);
        sel_n = 1'b0; iack_n = 1'b0; rd_wr = 1'b0; addr = 2'd1; wdata = 8'h00;
        @(negedge clk);
        check("R8", "iack wins vector", {24'd0, rdata}, {24'd0, m_vec});
        check("R8", "iack wins ack", {31'd0, xfer_ack_n}, 32'd0);
        sel_n = 1'b1; iack_n = 1'b1;
        @(negedge clk);
        bus_read(2'd1, "R8", 8'hFF);

        // Random phase
        for (int i = 0; i < 60; i++) begin
            logic [1:0] a;
            src_cond = 8'($urandom);
            @(negedge clk);
            @(negedge clk);
            check("R3", "random irq", {31'd0, irq_n}, {31'd0, exp_irq_n(src_cond, m_mask)});
            case ($urandom % 4)
                0: bus_write(2'd1, 8'($urandom) & 8'($urandom));
                1: bus_write(2'($urandom % 4), 8'($urandom));
                2: begin
                    a = 2'($urandom % 4);
                    bus_read(a, "R2", exp_read(a, src_cond, m_mask, m_vec));
                end
                default: iack_cycle(!exp_irq_n(src_cond, m_mask));
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule